// File: doc/BRIEF.md
# Ordered Speculative Write Buffer Merge

This block sits between a group of cores running speculative threads and a shared second-level cache. The threads are ranked by how speculative they are. The head thread is the least speculative one and runs non-speculatively. Its stores go straight to the cache port. Every other thread keeps its stores in a private line buffer, at byte granularity, so that no speculative data reaches the shared cache.

A line fetch names the requesting thread and a line address. The block reads the line from the cache and lays over it the buffered bytes that the requester is allowed to see. These are its own bytes and those of every thread ranked ahead of it. When several sources hold the same byte, the nearest one wins. Bytes held by more speculative threads are never shown.

When the head thread commits, the buffer of the next thread drains to the cache one entry per cycle once that thread becomes head. The head then advances in ring order, so buffered data reaches the cache strictly in thread order. A squashed thread's buffer is emptied.

Top module: `spec_wbuf_merge`

## Requirements
- R1: After reset, thread 0 is head, all buffers are empty, every `wr_ready` bit is 1 and `rsp_valid` is 0.
- R2: A head-thread write is accepted while the head's buffer is empty, and it appears on the cache write port in the same cycle, with `l2_wr_be` bit b enabling bits [8b+7:8b] of the line.
- R3: A write from a non-head thread is held in that thread's buffer and never drives the cache port. Writes to a line that is already buffered merge into the same entry byte by byte, so they use no extra capacity.
- R4: A non-head thread whose buffer holds DEPTH lines and whose write address misses has `wr_ready` low, and the write is not taken. The same thread can still write to lines it already holds. Once it becomes head and its buffer is empty, the write passes through to the cache.
- R5: A fetch presented with `rd_valid` returns `rsp_valid` and the merged line on the next cycle. For each byte the source is chosen in this order: the requester's own buffer first, then less-speculative buffers from nearest to farthest, then the cache.
- R6: A fetch never returns bytes buffered by a thread that is more speculative than the requester.
- R7: `squash[t]` for a non-head thread empties its buffer at the next edge, and a write from that thread in the same cycle is discarded. `squash` of the head thread is ignored.
- R8: While the head's buffer is not empty, one entry per cycle is written to the cache and the head's `wr_ready` is low.
- R9: A `commit` pulse is remembered. The head advances by exactly one (modulo the thread count) at the first edge where a commit is pending and the head's buffer is empty. Thread rank is (index − head) modulo the thread count.
- R10: After every thread has committed, each cache line holds the bytes that the thread order gives, with later threads' data laid over earlier threads' data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | N_THR | Per-thread write request |
| wr_addr | input | N_THR*AW | Per-thread line address |
| wr_data | input | N_THR*LINE_B*8 | Per-thread line data |
| wr_be | input | N_THR*LINE_B | Per-thread byte enables |
| wr_ready | output | N_THR | Write accepted this cycle when high with wr_valid |
| squash | input | N_THR | Discard the buffer of a restarted thread |
| commit | input | 1 | Head thread has finished |
| rd_valid | input | 1 | Line fetch request |
| rd_thread | input | $clog2(N_THR) | Requesting thread |
| rd_addr | input | AW | Fetch line address |
| rsp_valid | output | 1 | Fetch response valid |
| rsp_line | output | LINE_B*8 | Merged line |
| head_thread | output | $clog2(N_THR) | Current least-speculative thread |
| l2_rd_addr | output | AW | Cache read address |
| l2_rd_data | input | LINE_B*8 | Cache read data (same cycle) |
| l2_wr_en | output | 1 | Cache write strobe |
| l2_wr_addr | output | AW | Cache write address |
| l2_wr_data | output | LINE_B*8 | Cache write data |
| l2_wr_be | output | LINE_B | Cache write byte enables |

## Verification
The bench places overlapping byte writes from every rank on one line. A wrong merge order would return a less-speculative byte where the requester's own byte belongs, or leak a later thread's byte to an earlier reader. It fills a buffer and then writes both a new line and an already-held line. A buffer that failed to merge hits would stall the second write, and one that ignored capacity would accept the first. It squashes the head and a speculative thread while they write in the same cycle, and it commits while the head is still draining. A premature rotation or a dropped drain entry would leave the final cache image out of thread order.

// File: rtl/swb_pkg.sv
package swb_pkg;
   typedef enum logic {
      RSP_COMB = 1'b0,
      RSP_REG  = 1'b1
   } swb_rsp_e;
endpackage

// File: rtl/swb_tbuf.sv
module swb_tbuf #(
   parameter int AW     = 10,
   parameter int LINE_B = 8,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [LINE_B*8-1:0] wr_data,
   input  logic [LINE_B-1:0] wr_be,
   output logic              wr_block,
   input  logic              clear,
   input  logic [AW-1:0]     rd_addr,
   output logic [LINE_B-1:0] rd_be,
   output logic [LINE_B*8-1:0] rd_data,
   input  logic              drain_en,
   output logic              nonempty,
   output logic [AW-1:0]     drn_addr,
   output logic [LINE_B*8-1:0] drn_data,
   output logic [LINE_B-1:0] drn_be
);
   localparam int DW = LINE_B*8;
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DEPTH-1:0]  vld;
   logic [AW-1:0]     tag [DEPTH];
   logic [DW-1:0]     dat [DEPTH];
   logic [LINE_B-1:0] msk [DEPTH];

   logic [DEPTH-1:0] hit_w, hit_r;
   logic             hit_any, full, dup;
   logic [IW-1:0]    hit_idx, free_idx, wr_idx, drn_idx;

   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      drn_idx  = '0;
      rd_be    = '0;
      rd_data  = '0;
      for (int i = DEPTH-1; i >= 0; i--) begin
         hit_w[i] = vld[i] && (tag[i] == wr_addr);
         hit_r[i] = vld[i] && (tag[i] == rd_addr);
         if (hit_w[i]) hit_idx  = IW'(i);
         if (!vld[i])  free_idx = IW'(i);
         if (vld[i])   drn_idx  = IW'(i);
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (hit_r[i]) begin
            rd_be   = rd_be | msk[i];
            rd_data = rd_data | dat[i];
         end
      end
      hit_any  = |hit_w;
      full     = &vld;
      wr_idx   = hit_any ? hit_idx : free_idx;
      wr_block = full && !hit_any;
      nonempty = |vld;
      drn_addr = tag[drn_idx];
      drn_data = dat[drn_idx];
      drn_be   = msk[drn_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
      end else if (clear) begin
         vld <= '0;
      end else begin
         if (drain_en && nonempty) vld[drn_idx] <= 1'b0;
         if (wr_en && !hit_any && !full) vld[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !clear && !wr_block) begin
         if (hit_any) begin
            msk[wr_idx] <= msk[wr_idx] | wr_be;
         end else begin
            tag[wr_idx] <= wr_addr;
            msk[wr_idx] <= wr_be;
         end
         for (int b = 0; b < LINE_B; b++) begin
            if (wr_be[b]) dat[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
         end
      end
   end

   always_comb begin
      dup = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         for (int j = i+1; j < DEPTH; j++)
            if (vld[i] && vld[j] && tag[i] == tag[j]) dup = 1'b1;
   end

   assert_unique_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !dup);
   assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !nonempty);
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !wr_block);
endmodule

// File: rtl/swb_rank.sv
module swb_rank #(
   parameter int N_THR = 4,
   localparam int TW   = $clog2(N_THR)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  logic          head_empty,
   output logic [TW-1:0] head,
   output logic          rotate
);
   logic pend_q;

   assign rotate = pend_q && head_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head   <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= (pend_q && !rotate) || commit;
         if (rotate) head <= head + TW'(1);
      end
   end

   assert_rotate_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (head != $past(head)) |-> ($past(head_empty) && $past(pend_q)));
   assert_head_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (head != $past(head)) |-> (head == $past(head) + TW'(1)));
endmodule

// File: rtl/swb_merge.sv
module swb_merge #(
   parameter int N_THR  = 4,
   parameter int LINE_B = 8,
   localparam int TW    = $clog2(N_THR),
   localparam int DW    = LINE_B*8
) (
   input  logic [TW-1:0]         req,
   input  logic [TW-1:0]         head,
   input  logic [DW-1:0]         base,
   input  logic [N_THR*LINE_B-1:0] hit_be,
   input  logic [N_THR*DW-1:0]   hit_data,
   output logic [DW-1:0]         line
);
   logic [TW-1:0] rank, src;

   always_comb begin
      line = base;
      rank = req - head;
      src  = '0;
      for (int d = N_THR-1; d >= 0; d--) begin
         if (TW'(d) <= rank) begin
            src = req - TW'(d);
            for (int b = 0; b < LINE_B; b++) begin
               if (hit_be[int'(src)*LINE_B + b])
                  line[b*8 +: 8] = hit_data[int'(src)*DW + b*8 +: 8];
            end
         end
      end
   end
endmodule

// File: rtl/spec_wbuf_merge.sv
module spec_wbuf_merge #(
   parameter int N_THR  = 4,
   parameter int LINE_B = 8,
   parameter int AW     = 10,
   parameter int DEPTH  = 4,
   parameter swb_pkg::swb_rsp_e RSP_MODE = swb_pkg::RSP_REG,
   localparam int TW = $clog2(N_THR),
   localparam int DW = LINE_B*8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_THR-1:0]        wr_valid,
   input  logic [N_THR*AW-1:0]     wr_addr,
   input  logic [N_THR*DW-1:0]     wr_data,
   input  logic [N_THR*LINE_B-1:0] wr_be,
   output logic [N_THR-1:0]        wr_ready,
   input  logic [N_THR-1:0]        squash,
   input  logic                    commit,
   input  logic                    rd_valid,
   input  logic [TW-1:0]           rd_thread,
   input  logic [AW-1:0]           rd_addr,
   output logic                    rsp_valid,
   output logic [DW-1:0]           rsp_line,
   output logic [TW-1:0]           head_thread,
   output logic [AW-1:0]           l2_rd_addr,
   input  logic [DW-1:0]           l2_rd_data,
   output logic                    l2_wr_en,
   output logic [AW-1:0]           l2_wr_addr,
   output logic [DW-1:0]           l2_wr_data,
   output logic [LINE_B-1:0]       l2_wr_be
);
   if (N_THR < 2 || (N_THR & (N_THR-1)) != 0) begin : g_bad_thr
      $error("N_THR must be a power of two of at least 2");
   end
   if (DEPTH < 1 || LINE_B < 1 || AW < 1) begin : g_bad_dims
      $error("DEPTH, LINE_B and AW must be positive");
   end

   logic [TW-1:0]           head;
   logic                    rotate, head_busy;
   logic [N_THR-1:0]        is_head, buf_wr_en, buf_clear, buf_block, buf_nonempty;
   logic [N_THR*LINE_B-1:0] hit_be, drn_be;
   logic [N_THR*DW-1:0]     hit_data, drn_data;
   logic [N_THR*AW-1:0]     drn_addr;
   logic [DW-1:0]           merged;

   for (genvar g = 0; g < N_THR; g++) begin : g_thr
      assign is_head[g]   = (head == TW'(g));
      assign buf_clear[g] = squash[g] && !is_head[g];
      assign buf_wr_en[g] = wr_valid[g] && !is_head[g] && !buf_block[g] && !buf_clear[g];
      assign wr_ready[g]  = is_head[g] ? !buf_nonempty[g] : !buf_block[g];

      swb_tbuf #(.AW(AW), .LINE_B(LINE_B), .DEPTH(DEPTH)) tbuf_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (buf_wr_en[g]),
         .wr_addr  (wr_addr[g*AW +: AW]),
         .wr_data  (wr_data[g*DW +: DW]),
         .wr_be    (wr_be[g*LINE_B +: LINE_B]),
         .wr_block (buf_block[g]),
         .clear    (buf_clear[g]),
         .rd_addr  (rd_addr),
         .rd_be    (hit_be[g*LINE_B +: LINE_B]),
         .rd_data  (hit_data[g*DW +: DW]),
         .drain_en (is_head[g]),
         .nonempty (buf_nonempty[g]),
         .drn_addr (drn_addr[g*AW +: AW]),
         .drn_data (drn_data[g*DW +: DW]),
         .drn_be   (drn_be[g*LINE_B +: LINE_B])
      );
   end

   assign head_busy   = buf_nonempty[head];
   assign head_thread = head;
   assign l2_rd_addr  = rd_addr;

   always_comb begin
      if (head_busy) begin
         l2_wr_en   = 1'b1;
         l2_wr_addr = drn_addr[int'(head)*AW +: AW];
         l2_wr_data = drn_data[int'(head)*DW +: DW];
         l2_wr_be   = drn_be[int'(head)*LINE_B +: LINE_B];
      end else begin
         l2_wr_en   = wr_valid[head];
         l2_wr_addr = wr_addr[int'(head)*AW +: AW];
         l2_wr_data = wr_data[int'(head)*DW +: DW];
         l2_wr_be   = wr_be[int'(head)*LINE_B +: LINE_B];
      end
   end

   swb_rank #(.N_THR(N_THR)) rank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (commit),
      .head_empty (!head_busy),
      .head       (head),
      .rotate     (rotate)
   );

   swb_merge #(.N_THR(N_THR), .LINE_B(LINE_B)) merge_i (
      .req      (rd_thread),
      .head     (head),
      .base     (l2_rd_data),
      .hit_be   (hit_be),
      .hit_data (hit_data),
      .line     (merged)
   );

   if (RSP_MODE == swb_pkg::RSP_REG) begin : g_rsp_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_line  <= '0;
         end else begin
            rsp_valid <= rd_valid;
            if (rd_valid) rsp_line <= merged;
         end
      end
      assert_rsp_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid == $past(rd_valid));
   end else begin : g_rsp_comb
      assign rsp_valid = rd_valid;
      assign rsp_line  = merged;
   end

   assert_head_stalls_while_draining_R8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_nonempty[head] |-> (!wr_ready[head] && l2_wr_en));
   assert_spec_write_stays_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_wr_en && !buf_nonempty[head]) |-> wr_valid[head]);
endmodule

// File: tb/spec_wbuf_merge_tb.sv
module spec_wbuf_merge_tb_top;
   localparam int CLK_P = 10;
   localparam int N  = 4;
   localparam int AW = 4;
   localparam int LB = 4;
   localparam int DP = 2;
   localparam int DW = LB*8;
   localparam int NL = 1 << AW;

   logic clk = 1'b0;
   logic rst_n;
   logic [N-1:0]    wr_valid;
   logic [N*AW-1:0] wr_addr;
   logic [N*DW-1:0] wr_data;
   logic [N*LB-1:0] wr_be;
   logic [N-1:0]    wr_ready;
   logic [N-1:0]    squash;
   logic            commit, rd_valid;
   logic [1:0]      rd_thread;
   logic [AW-1:0]   rd_addr;
   logic            rsp_valid;
   logic [DW-1:0]   rsp_line;
   logic [1:0]      head_thread;
   logic [AW-1:0]   l2_rd_addr;
   logic [DW-1:0]   l2_rd_data;
   logic            l2_wr_en;
   logic [AW-1:0]   l2_wr_addr;
   logic [DW-1:0]   l2_wr_data;
   logic [LB-1:0]   l2_wr_be;

   logic [DW-1:0] mem [NL];

   int tests = 0;
   int fails = 0;

   // reference model state
   logic [7:0] rb [N][NL][LB];
   bit         rm [N][NL][LB];
   logic [7:0] rmem [NL][LB];
   int         mhead, mdrain;
   bit         mpend;

   always #(CLK_P/2) clk = ~clk;

   spec_wbuf_merge #(.N_THR(N), .LINE_B(LB), .AW(AW), .DEPTH(DP)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .wr_ready(wr_ready), .squash(squash),
      .commit(commit), .rd_valid(rd_valid), .rd_thread(rd_thread), .rd_addr(rd_addr),
      .rsp_valid(rsp_valid), .rsp_line(rsp_line), .head_thread(head_thread),
      .l2_rd_addr(l2_rd_addr), .l2_rd_data(l2_rd_data), .l2_wr_en(l2_wr_en),
      .l2_wr_addr(l2_wr_addr), .l2_wr_data(l2_wr_data), .l2_wr_be(l2_wr_be)
   );

   assign l2_rd_data = mem[l2_rd_addr];

   always @(posedge clk) begin
      if (l2_wr_en) begin
         for (int b = 0; b < LB; b++)
            if (l2_wr_be[b]) mem[l2_wr_addr][b*8 +: 8] <= l2_wr_data[b*8 +: 8];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int cnt(input int t);
      int c = 0;
      for (int a = 0; a < NL; a++) begin
         bit any = 0;
         for (int b = 0; b < LB; b++) any |= rm[t][a][b];
         if (any) c++;
      end
      return c;
   endfunction

   function automatic bit mready(input int t);
      int a = int'(wr_addr[t*AW +: AW]);
      bit held = 0;
      if (t == mhead) return (mdrain == 0);
      for (int b = 0; b < LB; b++) held |= rm[t][a][b];
      return !(cnt(t) >= DP && !held);
   endfunction

   function automatic logic [31:0] rmem_line(input int a);
      logic [31:0] v;
      for (int b = 0; b < LB; b++) v[b*8 +: 8] = rmem[a][b];
      return v;
   endfunction

   task automatic clr_in();
      wr_valid = '0; wr_addr = '0; wr_data = '0; wr_be = '0;
      squash = '0; commit = 1'b0; rd_valid = 1'b0; rd_thread = '0; rd_addr = '0;
   endtask

   task automatic drv_wr(input int t, input int a, input logic [31:0] d, input logic [3:0] be);
      wr_valid[t] = 1'b1;
      wr_addr[t*AW +: AW] = AW'(a);
      wr_data[t*DW +: DW] = d;
      wr_be[t*LB +: LB] = be;
   endtask

   task automatic drv_rd(input int t, input int a);
      rd_valid = 1'b1;
      rd_thread = 2'(t);
      rd_addr = AW'(a);
   endtask

   // one clock: compare ready and cache strobe before the edge, update model, compare response after it
   task automatic step();
      bit r [N];
      bit exp_v, exp_wen, rot;
      logic [31:0] exp_line;
      @(negedge clk);
      for (int t = 0; t < N; t++) begin
         r[t] = mready(t);
         chk(wr_ready[t] == r[t], "R4", $sformatf("wr_ready[%0d]", t), 32'(wr_ready[t]), 32'(r[t]));
      end
      exp_wen = (mdrain > 0) || (wr_valid[mhead] && r[mhead]);
      chk(l2_wr_en == exp_wen, "R3", "l2_wr_en", 32'(l2_wr_en), 32'(exp_wen));
      exp_v = rd_valid;
      exp_line = '0;
      if (rd_valid) begin
         int a = int'(rd_addr);
         int rt = int'(rd_thread);
         int rank = (rt - mhead + N) % N;
         for (int b = 0; b < LB; b++) begin
            logic [7:0] v = rmem[a][b];
            for (int d = rank; d >= 0; d--) begin
               int s = (rt - d + N) % N;
               if (rm[s][a][b]) v = rb[s][a][b];
            end
            exp_line[b*8 +: 8] = v;
         end
      end
      for (int t = 0; t < N; t++) begin
         int a = int'(wr_addr[t*AW +: AW]);
         bit acc = wr_valid[t] && r[t];
         if (t == mhead) begin
            if (acc)
               for (int b = 0; b < LB; b++)
                  if (wr_be[t*LB + b]) rmem[a][b] = wr_data[t*DW + b*8 +: 8];
         end else if (squash[t]) begin
            for (int x = 0; x < NL; x++)
               for (int b = 0; b < LB; b++) rm[t][x][b] = 0;
         end else if (acc) begin
            for (int b = 0; b < LB; b++)
               if (wr_be[t*LB + b]) begin
                  rb[t][a][b] = wr_data[t*DW + b*8 +: 8];
                  rm[t][a][b] = 1;
               end
         end
      end
      rot = mpend && (mdrain == 0);
      if (mdrain > 0) mdrain--;
      mpend = (mpend && !rot) || commit;
      if (rot) begin
         mhead = (mhead + 1) % N;
         mdrain = cnt(mhead);
         for (int x = 0; x < NL; x++)
            for (int b = 0; b < LB; b++)
               if (rm[mhead][x][b]) begin
                  rmem[x][b] = rb[mhead][x][b];
                  rm[mhead][x][b] = 0;
               end
      end
      @(posedge clk);
      #1;
      chk(rsp_valid == exp_v, "R5", "rsp_valid", 32'(rsp_valid), 32'(exp_v));
      if (exp_v) chk(rsp_line == exp_line, "R5", "rsp_line", rsp_line, exp_line);
      chk(int'(head_thread) == mhead, "R9", "head_thread", 32'(head_thread), 32'(mhead));
      clr_in();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      #(CLK_P*50000);
      fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      for (int a = 0; a < NL; a++) begin
         mem[a] = '0;
         for (int b = 0; b < LB; b++) begin
            rmem[a][b] = 8'h00;
            for (int t = 0; t < N; t++) begin rb[t][a][b] = 8'h00; rm[t][a][b] = 0; end
         end
      end
      mhead = 0; mdrain = 0; mpend = 0;
      clr_in();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(wr_ready == 4'hF, "R1", "wr_ready after reset", 32'(wr_ready), 32'hF);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
      chk(head_thread == 2'd0, "R1", "head after reset", 32'(head_thread), 0);
      @(posedge clk); #1;

      // R2 head write-through
      drv_wr(0, 3, 32'h11111111, 4'hF);
      step();
      chk(mem[3] == 32'h11111111, "R2", "write-through line 3", mem[3], 32'h11111111);

      // R3 speculative writes from every rank on one line
      drv_wr(1, 3, 32'h00002222, 4'b0011);
      drv_wr(2, 3, 32'h00333300, 4'b0110);
      drv_wr(3, 3, 32'h44000000, 4'b1000);
      step();
      chk(mem[3] == 32'h11111111, "R3", "cache untouched by speculative writes", mem[3], 32'h11111111);

      // R5 and R6 visibility per rank
      drv_rd(0, 3); step();
      chk(rsp_line == 32'h11111111, "R6", "head view line 3", rsp_line, 32'h11111111);
      drv_rd(1, 3); step();
      chk(rsp_line == 32'h11112222, "R6", "thread 1 view", rsp_line, 32'h11112222);
      drv_rd(2, 3); step();
      chk(rsp_line == 32'h11333322, "R5", "thread 2 view", rsp_line, 32'h11333322);
      drv_rd(3, 3); step();
      chk(rsp_line == 32'h44333322, "R5", "thread 3 view", rsp_line, 32'h44333322);

      // R3 merge into the same entry, then fill the buffer
      drv_wr(2, 3, 32'h00000055, 4'b0001); step();
      drv_wr(2, 5, 32'hA5A5A5A5, 4'hF); step();
      // R4 full buffer, missing line stalls
      drv_wr(2, 7, 32'h77777777, 4'hF);
      #1 chk(wr_ready[2] == 1'b0, "R4", "full buffer stalls miss", 32'(wr_ready[2]), 0);
      step();
      drv_rd(2, 7); step();
      chk(rsp_line == 32'h0, "R4", "stalled write not taken", rsp_line, 0);
      drv_wr(2, 3, 32'h66000000, 4'b1000); step();
      drv_rd(2, 3); step();
      chk(rsp_line == 32'h66333355, "R3", "hit merges while full", rsp_line, 32'h66333355);

      // R7 squash of speculative thread discards buffer and same-cycle write
      squash[3] = 1'b1;
      drv_wr(3, 9, 32'h99999999, 4'hF);
      step();
      drv_rd(3, 3); step();
      chk(rsp_line == 32'h66333355, "R7", "squashed thread loses own bytes", rsp_line, 32'h66333355);
      drv_rd(3, 9); step();
      chk(rsp_line == 32'h0, "R7", "write in squash cycle discarded", rsp_line, 0);

      // R7 squash of head ignored
      squash[0] = 1'b1;
      drv_wr(0, 2, 32'h12345678, 4'hF);
      step();
      chk(mem[2] == 32'h12345678, "R7", "head squash ignored", mem[2], 32'h12345678);

      // R9 commit, R8 drain with head stall and a pending commit
      commit = 1'b1; step();
      step();
      chk(head_thread == 2'd1, "R9", "head advanced to 1", 32'(head_thread), 1);
      drv_wr(1, 4, 32'h0BADF00D, 4'hF);
      #1 chk(wr_ready[1] == 1'b0, "R8", "head stalls while draining", 32'(wr_ready[1]), 0);
      commit = 1'b1;
      step();
      chk(mem[3] == 32'h11112222, "R8", "first drain entry", mem[3], 32'h11112222);
      step();
      chk(head_thread == 2'd2, "R9", "rotation after drain", 32'(head_thread), 2);

      // R4 stalled thread becomes head, drains, then writes through
      drv_wr(2, 7, 32'h77777777, 4'hF); step();
      drv_wr(2, 7, 32'h77777777, 4'hF); step();
      drv_wr(2, 7, 32'h77777777, 4'hF); step();
      chk(mem[7] == 32'h77777777, "R4", "write passes through as head", mem[7], 32'h77777777);

      commit = 1'b1; step();
      step();
      drv_wr(3, 9, 32'hCAFE0000, 4'b1100); step();
      commit = 1'b1; step();
      step();
      chk(head_thread == 2'd0, "R9", "head wraps to 0", 32'(head_thread), 0);
      idle(2);

      // R10 final image in thread order
      chk(mem[3] == 32'h66333355, "R10", "line 3 final", mem[3], 32'h66333355);
      chk(mem[5] == 32'hA5A5A5A5, "R10", "line 5 final", mem[5], 32'hA5A5A5A5);
      chk(mem[9] == 32'hCAFE0000, "R10", "line 9 final", mem[9], 32'hCAFE0000);
      chk(mem[4] == 32'h0, "R10", "line 4 untouched", mem[4], 0);
      for (int a = 0; a < NL; a++)
         chk(mem[a] == rmem_line(a), "R10", $sformatf("model line %0d", a), mem[a], rmem_line(a));

      summary();
      $finish;
   end
endmodule